// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This block is a two-stage pipelined integer ALU built from two 64-bit halves. In split mode each half runs its own 64-bit scalar operation, with its own opcode, in the same cycle. In joined mode one opcode drives both halves as a single 128-bit packed operation. The lanes are 8, 16 or 32 bits wide, picked at run time. Carries, saturation, shifts and compares all stop at the lane edges of the selected width.

The operations are add and subtract (wrapping or signed-saturating), signed min and max, absolute value, left shift and two right shifts, four bitwise functions, equality and signed greater-than masks, and narrowing pack and widening extend. A new operation can be issued on every cycle. Its result comes back with a valid flag exactly two cycles later.

Top module: `psimd_alu`

## Requirements
- R1: An operation presented with `valid_i` high before clock edge k gives its result on `result_o`, with `valid_o` high, right after edge k+1. One operation is accepted per cycle, and `valid_o` is low in cycles that carry no result.
- R2: With `joined_i` low, bits 63:0 of the result are `op_i` applied to bits 63:0 of the operands, and bits 127:64 are `op_hi_i` applied to bits 127:64. Each half is one 64-bit lane.
- R3: With `joined_i` high, `op_i` applies to all 128 bits and `op_hi_i` is ignored. `width_i` sets the lane width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits.
- R4: Opcode 0 (add) and opcode 1 (subtract, a-b) wrap modulo the lane width. No carry or borrow crosses a lane boundary.
- R5: Opcode 2 (add) and opcode 3 (subtract) treat lanes as signed and clamp to the lane's largest or smallest signed value on overflow.
- R6: Opcode 4 is signed min and opcode 5 is signed max. Opcode 6 is the absolute value of a's lane, where the most negative value maps to itself.
- R7: Opcode 7 shifts left, opcode 8 shifts right logically and opcode 9 shifts right arithmetically. The shift amount is b's lane modulo the lane width.
- R8: Opcodes 10, 11, 12 and 13 give AND, OR, XOR and NOR of a and b.
- R9: Opcode 14 (a==b) and opcode 15 (signed a>b) set a lane to all ones when the condition holds and to all zeros otherwise.
- R10: Opcode 16 (pack) works within each 64-bit half and narrows lanes of width W to W/2 by keeping each lane's low half. Bits 31:0 of the half take a's lanes and bits 63:32 take b's lanes, with lane order kept.
- R11: Opcode 17 sign-extends and opcode 18 zero-extends. Within each half, lanes of width S taken from a's low 32 bits are widened to 2S, in order. S is the lane width, and in split mode S is 32.
- R12: While reset is held, `valid_o` is 0 and `result_o` is 0.
- R13: Opcodes 19 to 31 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| joined_i | input | 1 | 1: one 128-bit packed op; 0: two 64-bit ops |
| width_i | input | 2 | Lane width in joined mode |
| op_i | input | 5 | Opcode (low half, or whole word when joined) |
| op_hi_i | input | 5 | Opcode for the upper half in split mode |
| a_i | input | 128 | Operand a |
| b_i | input | 128 | Operand b |
| valid_o | output | 1 | Result present |
| result_o | output | 128 | Result |

## Verification
Every result is due on the second rising edge after the cycle in which it was presented. The driver stamps each expected item with that cycle number, and the monitor, which samples on the falling edge, fails any result that arrives in a different cycle or with no item waiting. Back-to-back streams show that results neither merge nor get dropped. The reset value is checked on a falling edge while reset is still held.

// File: rtl/psimd_alu_pkg.sv
package psimd_alu_pkg;
  localparam int unsigned HALF_W = 64;
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned DATA_W = HALF_W * NUM_HALVES;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDS = 5'd2,  OP_SUBS = 5'd3,
    OP_MIN  = 5'd4,  OP_MAX  = 5'd5,  OP_ABS  = 5'd6,  OP_SLL  = 5'd7,
    OP_SRL  = 5'd8,  OP_SRA  = 5'd9,  OP_AND  = 5'd10, OP_OR   = 5'd11,
    OP_XOR  = 5'd12, OP_NOR  = 5'd13, OP_CEQ  = 5'd14, OP_CGT  = 5'd15,
    OP_PACK = 5'd16, OP_EXTS = 5'd17, OP_EXTZ = 5'd18
  } alu_op_e;

  // index i selects lane width 8<<i
  typedef enum logic [1:0] { LW_8 = 2'd0, LW_16 = 2'd1, LW_32 = 2'd2, LW_64 = 2'd3 } lane_w_e;
endpackage

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned SW = $clog2(W);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]    sum_x, dif_x;
  logic [W-1:0]  add_sat, sub_sat;
  logic          gt;
  logic [SW-1:0] sh;

  assign sum_x = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign dif_x = {a_i[W-1], a_i} - {b_i[W-1], b_i};
  assign add_sat = (sum_x[W] != sum_x[W-1]) ? (sum_x[W] ? S_MIN : S_MAX) : sum_x[W-1:0];
  assign sub_sat = (dif_x[W] != dif_x[W-1]) ? (dif_x[W] ? S_MIN : S_MAX) : dif_x[W-1:0];
  assign gt = $signed(a_i) > $signed(b_i);
  assign sh = b_i[SW-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = sum_x[W-1:0];
      OP_SUB:  y_o = dif_x[W-1:0];
      OP_ADDS: y_o = add_sat;
      OP_SUBS: y_o = sub_sat;
      OP_MIN:  y_o = gt ? b_i : a_i;
      OP_MAX:  y_o = gt ? a_i : b_i;
      OP_ABS:  y_o = a_i[W-1] ? (~a_i + 1'b1) : a_i;
      OP_SLL:  y_o = a_i << sh;
      OP_SRL:  y_o = a_i >> sh;
      OP_SRA:  y_o = W'($signed(a_i) >>> sh);
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOR:  y_o = ~(a_i | b_i);
      OP_CEQ:  y_o = {W{a_i == b_i}};
      OP_CGT:  y_o = {W{gt}};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/psimd_half.sv
module psimd_half
  import psimd_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  lane_w_e           lw_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [HALF_W-1:0] y_o
);
  localparam int unsigned NW = 4;
  localparam int unsigned QW = HALF_W / 2;

  logic [HALF_W-1:0] lane_y [NW];
  logic [HALF_W-1:0] pack_y [NW];
  logic [HALF_W-1:0] exts_y [NW];
  logic [HALF_W-1:0] extz_y [NW];

  for (genvar i = 0; i < NW; i++) begin : g_w
    localparam int unsigned W  = 8 << i;
    localparam int unsigned NL = HALF_W / W;
    localparam int unsigned HW = W / 2;
    localparam int unsigned S  = (W > QW) ? QW : W;
    localparam int unsigned NE = QW / S;
    logic [HALF_W-1:0] ly, py, sy, zy;

    for (genvar k = 0; k < NL; k++) begin : g_l
      psimd_lane #(.W(W)) u_lane (
        .op_i (op_i),
        .a_i  (a_i[k*W +: W]),
        .b_i  (b_i[k*W +: W]),
        .y_o  (ly[k*W +: W])
      );
      assign py[k*HW +: HW]      = a_i[k*W +: HW];
      assign py[QW + k*HW +: HW] = b_i[k*W +: HW];
    end

    for (genvar k = 0; k < NE; k++) begin : g_e
      assign sy[k*2*S +: 2*S] = {{S{a_i[k*S + S - 1]}}, a_i[k*S +: S]};
      assign zy[k*2*S +: 2*S] = {{S{1'b0}}, a_i[k*S +: S]};
    end

    assign lane_y[i] = ly;
    assign pack_y[i] = py;
    assign exts_y[i] = sy;
    assign extz_y[i] = zy;
  end

  always_comb begin
    unique case (op_i)
      OP_PACK: y_o = pack_y[lw_i];
      OP_EXTS: y_o = exts_y[lw_i];
      OP_EXTZ: y_o = extz_y[lw_i];
      default: y_o = lane_y[lw_i];
    endcase
  end
endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
  import psimd_alu_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         joined_i,
  input  logic [1:0]   width_i,
  input  logic [4:0]   op_i,
  input  logic [4:0]   op_hi_i,
  input  logic [127:0] a_i,
  input  logic [127:0] b_i,
  output logic         valid_o,
  output logic [127:0] result_o
);
  // stage 1: operand capture
  logic              s1_valid;
  alu_op_e           s1_op [NUM_HALVES];
  lane_w_e           s1_lw;
  logic [DATA_W-1:0] s1_a, s1_b;
  logic [DATA_W-1:0] s1_y;
  lane_w_e           lw_d;

  always_comb begin
    if (!joined_i)              lw_d = LW_64;
    else if (width_i == 2'd0)   lw_d = LW_8;
    else if (width_i == 2'd1)   lw_d = LW_16;
    else                        lw_d = LW_32;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_op[0] <= OP_ADD;
      s1_op[1] <= OP_ADD;
      s1_lw    <= LW_8;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_op[0] <= alu_op_e'(op_i);
      s1_op[1] <= alu_op_e'(joined_i ? op_i : op_hi_i);
      s1_lw    <= lw_d;
      s1_a     <= a_i;
      s1_b     <= b_i;
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    psimd_half u_half (
      .op_i (s1_op[h]),
      .lw_i (s1_lw),
      .a_i  (s1_a[h*HALF_W +: HALF_W]),
      .b_i  (s1_b[h*HALF_W +: HALF_W]),
      .y_o  (s1_y[h*HALF_W +: HALF_W])
    );
  end

  // stage 2: result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= s1_valid;
      result_o <= s1_y;
    end
  end
endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         joined_i,
  input logic [4:0]   op_i,
  input logic [4:0]   op_hi_i,
  input logic [127:0] a_i,
  input logic [127:0] b_i,
  input logic         valid_o,
  input logic [127:0] result_o
);
  logic [1:0] seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_add_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen >= 2'd2) && $past(valid_i && joined_i && op_i == 5'd0 && b_i == '0, 2))
      |-> (result_o == $past(a_i, 2)));

  p_logic_and_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen >= 2'd2) && $past(valid_i && op_i == 5'd10 && (joined_i || op_hi_i == 5'd10), 2))
      |-> (result_o == $past(a_i & b_i, 2)));

  p_cmp_eq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen >= 2'd2) && $past(valid_i && joined_i && op_i == 5'd14 && a_i == b_i, 2))
      |-> (result_o == '1));

  p_bad_op_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen >= 2'd2) && $past(valid_i && joined_i && op_i >= 5'd19, 2))
      |-> (result_o == '0));

  p_reset_r12: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && result_o == '0));
endmodule

bind psimd_alu psimd_alu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .joined_i (joined_i),
  .op_i     (op_i),
  .op_hi_i  (op_hi_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/psimd_alu_tb_top.sv
module psimd_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, joined_i = 1'b0;
  logic [1:0] width_i = '0;
  logic [4:0] op_i = '0, op_hi_i = '0;
  logic [127:0] a_i = '0, b_i = '0;
  logic valid_o;
  logic [127:0] result_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [127:0] val; int due; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psimd_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .joined_i(joined_i),
    .width_i(width_i), .op_i(op_i), .op_hi_i(op_hi_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] mk(int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic signed [65:0] sx(int w, logic [63:0] v);
    logic signed [65:0] r;
    r = $signed({2'b00, v & mk(w)});
    if (v[w-1]) r = r - (66'sd1 <<< w);
    return r;
  endfunction

  function automatic logic [63:0] m_lane(int w, int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] m = mk(w);
    logic signed [65:0] s, hi, lo;
    int sh = int'(b & 64'(w - 1));
    hi = (66'sd1 <<< (w - 1)) - 66'sd1;
    lo = -(66'sd1 <<< (w - 1));
    case (op)
      0: return (a + b) & m;
      1: return (a - b) & m;
      2, 3: begin
        s = (op == 2) ? sx(w, a) + sx(w, b) : sx(w, a) - sx(w, b);
        if (s > hi) s = hi;
        if (s < lo) s = lo;
        return s[63:0] & m;
      end
      4: return (sx(w, a) < sx(w, b)) ? a & m : b & m;
      5: return (sx(w, a) > sx(w, b)) ? a & m : b & m;
      6: begin s = sx(w, a); if (s < 0) s = -s; return s[63:0] & m; end
      7: return (a << sh) & m;
      8: return (a & m) >> sh;
      9: begin s = sx(w, a) >>> sh; return s[63:0] & m; end
      10: return a & b & m;
      11: return (a | b) & m;
      12: return (a ^ b) & m;
      13: return ~(a | b) & m;
      14: return ((a & m) == (b & m)) ? m : 64'd0;
      15: return (sx(w, a) > sx(w, b)) ? m : 64'd0;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] m_half(int w, int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    if (op == 16) begin
      for (int k = 0; k < 64 / w; k++) begin
        r |= ((a >> (k * w)) & mk(w / 2)) << (k * w / 2);
        r |= ((b >> (k * w)) & mk(w / 2)) << (32 + k * w / 2);
      end
    end else if (op == 17 || op == 18) begin
      int s = (w == 64) ? 32 : w;
      for (int k = 0; k < 32 / s; k++) begin
        logic [63:0] e = (a >> (k * s)) & mk(s);
        if (op == 17 && e[s-1]) e |= mk(2 * s) & ~mk(s);
        r |= e << (k * 2 * s);
      end
    end else begin
      for (int k = 0; k < 64 / w; k++)
        r |= m_lane(w, op, a >> (k * w), b >> (k * w)) << (k * w);
    end
    return r;
  endfunction

  task automatic issue(string tag, bit jn, int wsel, int op, int oph,
                       logic [127:0] a, logic [127:0] b);
    exp_t e;
    int w = !jn ? 64 : (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    valid_i = 1'b1; joined_i = jn; width_i = 2'(wsel);
    op_i = 5'(op); op_hi_i = 5'(oph); a_i = a; b_i = b;
    e.val = {m_half(w, jn ? op : oph, a[127:64], b[127:64]), m_half(w, op, a[63:0], b[63:0])};
    e.due = cyc + 2;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1: result %h with nothing expected", result_o);
      end else begin
        e = q.pop_front();
        if (e.due != cyc) begin
          fails++;
          $display("FAIL R1 (%s): arrived cycle %0d expected %0d", e.tag, cyc, e.due);
        end else if (result_o !== e.val) begin
          fails++;
          $display("FAIL %s: got %h expected %h", e.tag, result_o, e.val);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      fails++;
      $display("FAIL R12: valid %b result %h expected 0 0", valid_o, result_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 split: different ops per half
    issue("R2", 0, 0, 0, 1, {64'd10, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd3, 64'd1});
    issue("R2", 0, 0, 15, 5, {64'h8000_0000_0000_0000, 64'd5}, {64'd7, 64'hFFFF_FFFF_FFFF_FFFF});
    // R4 carries stop at lanes, back-to-back (R1)
    issue("R4", 1, 0, 0, 0, {16{8'hFF}}, {16{8'h01}});
    issue("R4", 1, 1, 0, 0, {8{16'hFFFF}}, {8{16'h0001}});
    issue("R4", 1, 2, 1, 0, {4{32'h0}}, {4{32'h1}});
    issue("R4", 1, 0, 0, 0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h0);
    // R3 width 3 acts as 32, op_hi ignored
    issue("R3", 1, 3, 0, 13, {4{32'hFFFF_FFFF}}, {4{32'h1}});
    // R5 saturation
    issue("R5", 1, 0, 2, 0, {8{8'h7F, 8'h80}}, {8{8'h01, 8'hFF}});
    issue("R5", 1, 1, 3, 0, {4{16'h8000, 16'h7FFF}}, {4{16'h0001, 16'hFFFF}});
    issue("R5", 0, 0, 2, 3, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, {64'd1, 64'd1});
    // R6
    issue("R6", 1, 0, 4, 0, {8{8'h80, 8'h05}}, {8{8'h7F, 8'hFB}});
    issue("R6", 1, 2, 5, 0, {2{32'h8000_0000, 32'h10}}, {2{32'h1, 32'hFFFF_FFF0}});
    issue("R6", 1, 0, 6, 0, {4{8'h80, 8'hFF, 8'h7F, 8'h00}}, '0);
    // R7 shifts, amounts beyond lane width wrap
    issue("R7", 1, 0, 7, 0, {16{8'h81}}, {4{8'd1, 8'd9, 8'd7, 8'd0}});
    issue("R7", 1, 1, 8, 0, {8{16'h8001}}, {2{16'd4, 16'd17, 16'd15, 16'd0}});
    issue("R7", 1, 2, 9, 0, {4{32'h8000_00F0}}, {32'd4, 32'd36, 32'd31, 32'd0});
    issue("R7", 0, 0, 9, 8, {2{64'h8000_0000_0000_0000}}, {64'd65, 64'd65});
    // R8
    issue("R8", 1, 0, 10, 0, 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555, 128'hFF00_FF00_0FF0_F00F_1111_2222_3333_4444);
    issue("R8", 0, 0, 11, 12, 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555, 128'hFF00_FF00_0FF0_F00F_1111_2222_3333_4444);
    issue("R8", 1, 1, 13, 0, 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555, 128'hFF00_FF00_0FF0_F00F_1111_2222_3333_4444);
    // R9
    issue("R9", 1, 0, 14, 0, {8{8'h12, 8'h34}}, {8{8'h12, 8'h35}});
    issue("R9", 1, 1, 15, 0, {4{16'hFFFF, 16'h0002}}, {4{16'h0001, 16'h0001}});
    issue("R9", 1, 2, 14, 0, {4{32'hCAFE_F00D}}, {4{32'hCAFE_F00D}});
    // R10 pack
    issue("R10", 1, 1, 16, 0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 128'h1020_3040_5060_7080_90A0_B0C0_D0E0_F000);
    issue("R10", 0, 0, 16, 16, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 128'h1020_3040_5060_7080_90A0_B0C0_D0E0_F000);
    // R11 extend
    issue("R11", 1, 0, 17, 0, 128'h0000_0000_80FF_017F_0000_0000_8001_FE02, '0);
    issue("R11", 1, 1, 18, 0, 128'h0000_0000_80FF_017F_0000_0000_8001_FE02, '0);
    issue("R11", 0, 0, 17, 18, 128'h0000_0000_8000_0001_0000_0000_8000_0001, '0);
    // R13
    issue("R13", 1, 0, 19, 0, '1, '1);
    issue("R13", 1, 2, 31, 0, '1, 128'h5);
    idle(1);
    // R1 gap then stream of mixed ops
    for (int i = 0; i < 40; i++) begin
      logic [127:0] a = {4{32'(i * 32'h9E37_79B9)}} ^ {128'(i) << 67};
      logic [127:0] b = {4{32'(i * 32'h85EB_CA6B + 7)}};
      issue("R1", i[0], i % 3, i % 19, (i + 5) % 19, a, b);
    end
    idle(5);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d results missing expected 0", q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule